// File: doc/BRIEF.md
# Successive-Approximation A/D Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter inside a microcontroller. Software reaches it through a small register port. One control register holds a conversion-clock selection, an analog channel selection, a start/busy bit and an enable bit. A status register holds the completion flag and the interrupt enable. A third address returns the last result. Once enabled, the block keeps acquiring the selected channel. When software sets the start bit, it runs eight trial steps against an external comparator. The trial code drives an external DAC. When the steps are done, the block stores the code, raises the completion flag and holds off for a fixed number of converter clock periods before another conversion may start.

The converter clock period (TAD) comes either from a divider on the system clock or from a slow free-running RC oscillator input, which is synchronized into the system clock domain. The two kinds of clock treat a sleep request in different ways. On a divided system clock, sleep aborts a running conversion: no flag is raised and the converter is powered down. On the RC clock, the conversion runs to completion during sleep. After the hold-off, the block either pulses a wake output (interrupt enabled) or powers the converter down and stays asleep.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While the enable bit (control bit 0) is 0, the converter is off (`adc_on` low, `dac_code` 0) and no conversion runs. Writing enable to 0 during a conversion aborts it: `adc_on` falls one cycle after the write edge and no flag is raised.
- R2: The control register (address 0) is laid out as [7:6] clock select, [5:3] channel, [2] start/busy, [1] reserved, [0] enable. It resets to 0x00, and the reserved bit always reads 0.
- R3: The result is read at address 1. The status register is at address 2, with bit 0 the completion flag and bit 1 the interrupt enable; it resets to 0x00. `chan_sel` follows the channel field.
- R4: Clock select 0, 1 and 2 give a TAD of 2, 8 and 32 system clocks. With a divided clock, the flag rises 8*TAD+1 cycles after the edge that writes the start bit.
- R5: On completion, the start bit clears, the flag sets and the result is loaded. A start written right after completion begins its conversion only 2 TAD after the completion edge (2*TAD cycles after its own write edge).
- R6: Conversion is MSB first, one bit per TAD. It begins at trial code 0x80. A bit is kept when `cmp_ge` is 1. An ideal comparator makes the result equal to the input.
- R7: A write of the start bit is ignored while the stored enable is 0, and also when the same write sets enable.
- R8: Clock select 3 (RC) delays the start of conversion by INSTR_CYC (default 4) system clocks beyond the divided-clock case.
- R9: With a divided clock, `sleep_req` during a conversion aborts it at the next edge. The start bit clears, the flag stays 0 and `adc_on` falls. The converter stays off until `sleep_req` is released, then acquisition resumes.
- R10: With the RC clock, a conversion under `sleep_req` completes and sets the flag. After the 2-TAD hold-off it pulses `wake` for one cycle if the interrupt enable is 1. Otherwise it powers down (`adc_on` low) without a wake.
- R11: The result register keeps its value across `rst_n`. Writing 0 to the flag bit clears it, and writing 1 there has no effect.
- R12: `dac_code` is 0 outside conversion and never 0 during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (result register not affected) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cmp_ge | input | 1 | Comparator: analog input at or above DAC level |
| dac_code | output | 8 | Trial code for the DAC |
| chan_sel | output | 3 | Analog multiplexer channel |
| adc_on | output | 1 | Converter analog power enable |
| rc_clk | input | 1 | Asynchronous internal RC oscillator clock |
| sleep_req | input | 1 | Core is in low-power sleep |
| wake | output | 1 | One-cycle wake request to the core |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
The bench counts cycles from the start write to the flag for each divider setting, and follows the trial code through its first steps. A divider off by one, or a SAR that drops or keeps the wrong bit, shows up as a wrong latency or a wrong intermediate code. It starts a conversion right after completion to catch a hold-off that is too short or missing. It also measures the extra start delay on the RC clock. Sleep is applied under both kinds of clock. A design that confused the two would abort an RC conversion, or would raise the flag after a divided-clock abort, or would wake the core with the interrupt disabled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_ACQ,
      ST_DLY,
      ST_CONV,
      ST_HOLD,
      ST_PDN
   } seq_state_e;

   typedef enum logic [1:0] {
      CS_DIV_A = 2'd0,
      CS_DIV_B = 2'd1,
      CS_DIV_C = 2'd2,
      CS_RC    = 2'd3
   } clk_sel_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_RES  = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   localparam int CTL_EN    = 0;
   localparam int CTL_GO    = 2;
   localparam int CTL_CH_LO = 3;
   localparam int CTL_CS_LO = 6;

   localparam int STA_FLAG = 0;
   localparam int STA_IE   = 1;

endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen #(
   parameter int DIV_A   = 2,
   parameter int DIV_B   = 8,
   parameter int DIV_C   = 32,
   parameter int RC_SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   input  logic       rc_clk,
   output logic       tick
);
   localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
   localparam int MAX_D  = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
   localparam int CNT_W  = (MAX_D > 2) ? $clog2(MAX_D) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             rc_edge;
   logic             div_tick;

   always_comb begin
      case (sel)
         2'd0:    lim = CNT_W'(DIV_A - 1);
         2'd1:    lim = CNT_W'(DIV_B - 1);
         default: lim = CNT_W'(DIV_C - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!run)        cnt_q <= '0;
      else if (cnt_q == lim) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
   end

   assign div_tick = run && (cnt_q == lim);

   generate
      if (RC_SYNC == 0) begin : g_rc_direct
         assign rc_edge = rc_clk;
      end else begin : g_rc_sync
         logic [RC_SYNC:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[RC_SYNC-1:0], rc_clk};
         end
         assign rc_edge = sh_q[RC_SYNC-1] & ~sh_q[RC_SYNC];
      end
   endgenerate

   assign tick = (sel == 2'd3) ? (run && rc_edge) : div_tick;

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         conv,
   input  logic         tick,
   input  logic         cmp_ge,
   output logic [W-1:0] trial,
   output logic         done,
   output logic [W-1:0] res
);
   localparam int IW = (W > 2) ? $clog2(W) : 1;

   logic [W-1:0]  code_q;
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!conv) begin
         code_q <= {1'b1, {(W-1){1'b0}}};
         idx_q  <= IW'(W - 1);
      end else if (tick) begin
         code_q[idx_q] <= cmp_ge;
         if (idx_q != '0) begin
            code_q[idx_q - 1'b1] <= 1'b1;
            idx_q                <= idx_q - 1'b1;
         end
      end
   end

   assign done = conv && tick && (idx_q == '0);

   always_comb begin
      res    = code_q;
      res[0] = cmp_ge;
   end

   assign trial = conv ? code_q : '0;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int INSTR_CYC = 4,
   parameter int HOLD_TAD  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic go,
   input  logic rc_mode,
   input  logic sleep_req,
   input  logic ie,
   input  logic tick,
   input  logic sar_done,
   output logic go_clr,
   output logic flag_set,
   output logic wake,
   output logic adc_on,
   output logic in_conv,
   output logic tad_run
);
   localparam int DLY_W  = $clog2(INSTR_CYC + 1);
   localparam int HOLD_W = $clog2(HOLD_TAD + 1);

   seq_state_e        st_q, st_d;
   logic [DLY_W-1:0]  dly_q;
   logic [HOLD_W-1:0] hold_q;
   logic              wake_d;

   always_comb begin
      st_d     = st_q;
      go_clr   = 1'b0;
      flag_set = 1'b0;
      wake_d   = 1'b0;
      case (st_q)
         ST_OFF:  if (en) st_d = ST_ACQ;
         ST_ACQ:  if (go) st_d = rc_mode ? ST_DLY : ST_CONV;
         ST_DLY:  if (dly_q == DLY_W'(INSTR_CYC - 1)) st_d = ST_CONV;
         ST_CONV: begin
            if (!rc_mode && sleep_req) begin
               st_d   = ST_PDN;
               go_clr = 1'b1;
            end else if (sar_done) begin
               st_d     = ST_HOLD;
               go_clr   = 1'b1;
               flag_set = 1'b1;
            end
         end
         ST_HOLD: begin
            if (tick && hold_q == HOLD_W'(HOLD_TAD - 1)) begin
               if (!sleep_req) begin
                  st_d = ST_ACQ;
               end else if (rc_mode && ie) begin
                  st_d   = ST_ACQ;
                  wake_d = 1'b1;
               end else begin
                  st_d = ST_PDN;
               end
            end
         end
         ST_PDN:  if (!sleep_req) st_d = ST_ACQ;
         default: st_d = ST_OFF;
      endcase
      if (!en) begin
         st_d     = ST_OFF;
         flag_set = 1'b0;
         wake_d   = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_OFF;
         wake <= 1'b0;
      end else begin
         st_q <= st_d;
         wake <= wake_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || st_q != ST_DLY) dly_q <= '0;
      else                          dly_q <= dly_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || st_q != ST_HOLD) hold_q <= '0;
      else if (tick)                 hold_q <= hold_q + 1'b1;
   end

   assign adc_on  = (st_q != ST_OFF) && (st_q != ST_PDN);
   assign in_conv = (st_q == ST_CONV);
   assign tad_run = (st_q == ST_CONV) || (st_q == ST_HOLD);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DIV_A     = 2,
   parameter int DIV_B     = 8,
   parameter int DIV_C     = 32,
   parameter int INSTR_CYC = 4,
   parameter int HOLD_TAD  = 2,
   parameter int RC_SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cmp_ge,
   output logic [DATA_W-1:0] dac_code,
   output logic [2:0]        chan_sel,
   output logic              adc_on,
   input  logic              rc_clk,
   input  logic              sleep_req,
   output logic              wake,
   output logic              irq_flag
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("adc_seq_ctrl: register layout needs DATA_W == 8");
      end
      if (DIV_A < 2 || DIV_B < 2 || DIV_C < 2) begin : g_bad_div
         $error("adc_seq_ctrl: every divider must be at least 2");
      end
      if (INSTR_CYC < 1 || HOLD_TAD < 1) begin : g_bad_cnt
         $error("adc_seq_ctrl: INSTR_CYC and HOLD_TAD must be at least 1");
      end
      if (RC_SYNC < 0) begin : g_bad_sync
         $error("adc_seq_ctrl: RC_SYNC must not be negative");
      end
   endgenerate

   logic [1:0]        clk_sel_q;
   logic [2:0]        chan_q;
   logic              go_q;
   logic              en_q;
   logic              ie_q;
   logic              flag_q;
   logic [DATA_W-1:0] result_q;

   logic ctrl_wr, stat_wr;
   logic go_clr, flag_set, in_conv, tad_run, tad_tick;
   logic sar_done, rc_mode;
   logic [DATA_W-1:0] sar_res;

   assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
   assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
   assign rc_mode = (clk_sel_q == CS_RC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_sel_q <= '0;
         chan_q    <= '0;
         en_q      <= 1'b0;
      end else if (ctrl_wr) begin
         clk_sel_q <= reg_wdata[CTL_CS_LO +: 2];
         chan_q    <= reg_wdata[CTL_CH_LO +: 3];
         en_q      <= reg_wdata[CTL_EN];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                       go_q <= 1'b0;
      else if (ctrl_wr && !reg_wdata[CTL_EN])           go_q <= 1'b0;
      else if (ctrl_wr && reg_wdata[CTL_GO] && en_q)    go_q <= 1'b1;
      else if (go_clr)                                  go_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ie_q   <= 1'b0;
      end else begin
         if (flag_set)                              flag_q <= 1'b1;
         else if (stat_wr && !reg_wdata[STA_FLAG])  flag_q <= 1'b0;
         if (stat_wr) ie_q <= reg_wdata[STA_IE];
      end
   end

   always_ff @(posedge clk) begin
      if (flag_set) result_q <= sar_res;
   end

   adc_tad_gen #(
      .DIV_A   (DIV_A),
      .DIV_B   (DIV_B),
      .DIV_C   (DIV_C),
      .RC_SYNC (RC_SYNC)
   ) u_tad (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (tad_run),
      .sel    (clk_sel_q),
      .rc_clk (rc_clk),
      .tick   (tad_tick)
   );

   adc_sar_core #(
      .W (DATA_W)
   ) u_sar (
      .clk    (clk),
      .conv   (in_conv),
      .tick   (tad_tick),
      .cmp_ge (cmp_ge),
      .trial  (dac_code),
      .done   (sar_done),
      .res    (sar_res)
   );

   adc_seq_fsm #(
      .INSTR_CYC (INSTR_CYC),
      .HOLD_TAD  (HOLD_TAD)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .go        (go_q),
      .rc_mode   (rc_mode),
      .sleep_req (sleep_req),
      .ie        (ie_q),
      .tick      (tad_tick),
      .sar_done  (sar_done),
      .go_clr    (go_clr),
      .flag_set  (flag_set),
      .wake      (wake),
      .adc_on    (adc_on),
      .in_conv   (in_conv),
      .tad_run   (tad_run)
   );

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = {clk_sel_q, chan_q, go_q, 1'b0, en_q};
         ADDR_RES:  reg_rdata = result_q;
         ADDR_STAT: reg_rdata = {{(DATA_W-2){1'b0}}, ie_q, flag_q};
         default:   reg_rdata = '0;
      endcase
   end

   assign chan_sel = chan_q;
   assign irq_flag = flag_q;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       en_q,
   input logic       go_q,
   input logic       ie_q,
   input logic [1:0] clk_sel_q,
   input logic       in_conv,
   input logic       sleep_req,
   input logic       adc_on,
   input logic       irq_flag,
   input logic       wake,
   input logic [7:0] dac_code
);
   // R1
   off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !adc_on);

   // R7
   no_start_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !go_q);

   // R5
   flag_from_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(in_conv));

   // R9
   sleep_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_conv && sleep_req && en_q && clk_sel_q != 2'd3 && !reg_wr)
      |=> (!go_q && !adc_on && !$rose(irq_flag)));

   // R10
   wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> ($past(ie_q) && $past(clk_sel_q) == 2'd3));

   // R12
   trial_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_conv |-> (dac_code != 8'h00));

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .en_q      (en_q),
   .go_q      (go_q),
   .ie_q      (ie_q),
   .clk_sel_q (clk_sel_q),
   .in_conv   (in_conv),
   .sleep_req (sleep_req),
   .adc_on    (adc_on),
   .irq_flag  (irq_flag),
   .wake      (wake),
   .dac_code  (dac_code)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       cmp_ge;
   logic [7:0] dac_code;
   logic [2:0] chan_sel;
   logic       adc_on;
   logic       rc_clk = 1'b0;
   logic       sleep_req = 1'b0;
   logic       wake;
   logic       irq_flag;
   logic [7:0] vin = 8'h00;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   always begin
      repeat (3) @(posedge clk);
      #2 rc_clk = ~rc_clk;
   end

   assign cmp_ge = (vin >= dac_code);

   adc_seq_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cmp_ge    (cmp_ge),
      .dac_code  (dac_code),
      .chan_sel  (chan_sel),
      .adc_on    (adc_on),
      .rc_clk    (rc_clk),
      .sleep_req (sleep_req),
      .wake      (wake),
      .irq_flag  (irq_flag)
   );

   task automatic report();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] cw(input logic [1:0] sel, input logic [2:0] ch,
                                     input logic go, input logic en);
      return {sel, ch, go, 1'b0, en};
   endfunction

   // caller is at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_flag(output int n);
      n = 0;
      while (!irq_flag && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); chk("R2 control reset value", d, 8'h00);
      rd(2'd2, d); chk("R3 status reset value", d, 8'h00);
      chk("R1 off after reset", {adc_on, dac_code}, 9'h000);
      wr(2'd0, 8'h02);
      rd(2'd0, d); chk("R2 reserved bit reads 0", d, 8'h00);
   endtask

   task automatic t_start_ignored();
      logic [7:0] d;
      wr(2'd0, cw(2'd0, 3'd0, 1'b1, 1'b0));
      rd(2'd0, d); chk("R7 start ignored while disabled", d, 8'h00);
      repeat (5) @(negedge clk);
      chk("R1 no power while disabled", adc_on, 1'b0);
      wr(2'd0, cw(2'd0, 3'd0, 1'b1, 1'b1));
      rd(2'd0, d); chk("R7 start ignored in enabling write", d, 8'h01);
      repeat (30) @(negedge clk);
      chk("R7 no conversion after ignored start", {irq_flag, dac_code}, 9'h000);
      chk("R1 acquiring once enabled", adc_on, 1'b1);
   endtask

   task automatic t_timing(input logic [1:0] sel, input int div);
      int n;
      logic [7:0] d;
      vin = 8'h5A;
      wr(2'd0, cw(sel, 3'd2, 1'b0, 1'b1));
      chk("R3 channel output", chan_sel, 3'd2);
      wr(2'd0, cw(sel, 3'd2, 1'b1, 1'b1));
      @(negedge clk);
      chk("R6 first trial code", dac_code, 8'h80);
      repeat (div) @(negedge clk);
      chk("R6 second trial code", dac_code, 8'h40);
      repeat (div) @(negedge clk);
      chk("R6 third trial code", dac_code, 8'h60);
      wait_flag(n);
      chk("R4 conversion latency", n + 1 + 2 * div, 8 * div + 1);
      rd(2'd1, d); chk("R5 result loaded", d, 8'h5A);
      rd(2'd0, d); chk("R5 start bit cleared", d[2], 1'b0);
      wr(2'd2, 8'h00);
      repeat (3 * div + 4) @(negedge clk);
   endtask

   task automatic t_sar(input logic [7:0] v);
      int n;
      logic [7:0] d;
      vin = v;
      wr(2'd0, cw(2'd0, 3'd1, 1'b1, 1'b1));
      wait_flag(n);
      rd(2'd1, d); chk("R6 result equals input", d, v);
      wr(2'd2, 8'h00);
      repeat (8) @(negedge clk);
   endtask

   task automatic t_hold();
      int n;
      vin = 8'h33;
      wr(2'd0, cw(2'd1, 3'd0, 1'b1, 1'b1));
      wait_flag(n);
      wr(2'd0, cw(2'd1, 3'd0, 1'b1, 1'b1));
      repeat (15) @(negedge clk);
      chk("R5 hold-off still active", dac_code, 8'h00);
      @(negedge clk);
      chk("R5 next conversion after 2 TAD", dac_code, 8'h80);
      wait_flag(n);
      wr(2'd2, 8'h00);
      repeat (30) @(negedge clk);
   endtask

   task automatic t_disable_abort();
      int n;
      logic [7:0] d;
      vin = 8'hC3;
      wr(2'd0, cw(2'd0, 3'd2, 1'b1, 1'b1));
      repeat (4) @(negedge clk);
      wr(2'd0, cw(2'd0, 3'd2, 1'b0, 1'b0));
      rd(2'd0, d); chk("R1 disable clears start", d, 8'h10);
      @(negedge clk);
      chk("R1 powered down after disable", {adc_on, dac_code}, 9'h000);
      repeat (40) @(negedge clk);
      chk("R1 no flag after disable", irq_flag, 1'b0);
      wr(2'd0, cw(2'd0, 3'd0, 1'b0, 1'b1));
      @(negedge clk);
   endtask

   task automatic t_rc_delay();
      int n;
      logic [7:0] d;
      vin = 8'h9E;
      wr(2'd0, cw(2'd3, 3'd0, 1'b0, 1'b1));
      wr(2'd0, cw(2'd3, 3'd0, 1'b1, 1'b1));
      repeat (4) @(negedge clk);
      chk("R8 RC start still delayed", dac_code, 8'h00);
      @(negedge clk);
      chk("R8 RC conversion begins", dac_code, 8'h80);
      wait_flag(n);
      rd(2'd1, d); chk("R8 RC result", d, 8'h9E);
      wr(2'd2, 8'h00);
      repeat (40) @(negedge clk);
   endtask

   task automatic t_sleep_abort();
      logic [7:0] d;
      vin = 8'h71;
      wr(2'd0, cw(2'd2, 3'd0, 1'b1, 1'b1));
      repeat (40) @(negedge clk);
      sleep_req = 1'b1;
      @(negedge clk);
      chk("R9 power down on abort", adc_on, 1'b0);
      rd(2'd0, d); chk("R9 start cleared on abort", d[2], 1'b0);
      repeat (300) @(negedge clk);
      chk("R9 flag stays 0", irq_flag, 1'b0);
      chk("R9 stays off while asleep", adc_on, 1'b0);
      sleep_req = 1'b0;
      @(negedge clk);
      chk("R9 acquisition resumes", adc_on, 1'b1);
   endtask

   task automatic t_rc_sleep(input logic ie);
      int n;
      bit seen;
      logic [7:0] d;
      vin = ie ? 8'h2B : 8'hE4;
      wr(2'd2, {6'b0, ie, 1'b0});
      wr(2'd0, cw(2'd3, 3'd0, 1'b1, 1'b1));
      sleep_req = 1'b1;
      seen = 1'b0;
      n = 0;
      while (n < 3000) begin
         @(negedge clk);
         n++;
         if (wake) seen = 1'b1;
         if (ie && seen) break;
         if (!ie && !adc_on) break;
      end
      rd(2'd1, d);
      if (ie) begin
         chk("R10 wake pulse with interrupt enabled", seen, 1'b1);
         chk("R10 flag set before wake", irq_flag, 1'b1);
         chk("R10 converter on after wake", adc_on, 1'b1);
         chk("R10 RC result under sleep", d, 8'h2B);
         @(negedge clk);
         chk("R10 wake lasts one cycle", wake, 1'b0);
      end else begin
         chk("R10 powered down without wake", {seen, adc_on}, 2'b00);
         chk("R10 flag set while staying asleep", irq_flag, 1'b1);
         chk("R10 RC result under sleep", d, 8'hE4);
      end
      sleep_req = 1'b0;
      wr(2'd2, 8'h00);
      repeat (40) @(negedge clk);
   endtask

   task automatic t_flag_and_reset();
      int n;
      logic [7:0] d;
      vin = 8'h4D;
      wr(2'd0, cw(2'd0, 3'd0, 1'b1, 1'b1));
      wait_flag(n);
      wr(2'd2, 8'h01);
      chk("R11 writing 1 keeps flag", irq_flag, 1'b1);
      wr(2'd2, 8'h00);
      chk("R11 writing 0 clears flag", irq_flag, 1'b0);
      wr(2'd2, 8'h01);
      chk("R11 writing 1 does not set flag", irq_flag, 1'b0);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd1, d); chk("R11 result kept across reset", d, 8'h4D);
      rd(2'd0, d); chk("R2 control cleared by reset", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_start_ignored();
      t_timing(2'd0, 2);
      t_timing(2'd1, 8);
      t_timing(2'd2, 32);
      t_sar(8'h00);
      t_sar(8'hFF);
      t_sar(8'hA5);
      t_sar(8'h3C);
      t_sar(8'h80);
      t_sar(8'h7F);
      t_hold();
      t_disable_abort();
      t_rc_delay();
      t_sleep_abort();
      t_rc_sleep(1'b1);
      t_rc_sleep(1'b0);
      t_flag_and_reset();
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      report();
   end

endmodule